// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block carries out the processor's entry into an interrupt handler once an interrupt has been accepted. At an instruction-decode boundary it takes the accepted request, made of a vector number and a priority level, and suppresses the instruction that was just decoded so that it never executes. It then drives a single-port memory through a fixed series of accesses. First it reads the handler address from the vector table. Next it pushes the old status word onto a descending stack, and after that the address of the suppressed instruction. It finishes with one cycle that hands the pipeline the handler address, the new status word and the new stack pointer, with the mask field replaced by the accepted level.

The redirect is not a delayed branch. No instruction executes between the last push and the first handler instruction. While a sequence is running, the block raises a busy flag, and no further request can be taken until it ends. Each memory access keeps its request, address, direction and write data steady until the memory acknowledges it with ready.

Top module: `irq_entry_seq`

## Requirements
- R1: When the block is idle and both decodeValid and reqValid are high, suppress is high in that same cycle and busy is high from the next cycle.
- R2: The first memory access after acceptance is a read (memWe low) at vecBase + 4 × reqVector.
- R3: The second access is a write (memWe high) of the unmodified cpuSr value to cpuSp − 4.
- R4: The third access is a write of decodePc, the address of the suppressed instruction, to cpuSp − 8.
- R5: jumpValid is high for exactly one cycle, in the cycle right after the third access is acknowledged. jumpPc equals the word read in the first access, and memReq is low in that cycle.
- R6: jumpSr equals cpuSr with bits 7:4 (the four mask bits) replaced by reqLevel, and all other bits unchanged.
- R7: jumpSp equals cpuSp − 8.
- R8: While busy is high, suppress stays low, and a request neither starts a sequence nor adds a memory access. memReq is never high while busy is low.
- R9: While memReq is high and memReady is low, memReq stays high on the next cycle and memAddr, memWe and memWdata keep their values.
- R10: After reset, busy, memReq, jumpValid and suppress are low.
- R11: A request presented in the jump cycle is not accepted then. If it is still present on the next cycle, it is accepted there and runs a full sequence.
- R12: busy falls in the cycle after jumpValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| decodeValid | input | 1 | An instruction is at the decode boundary |
| decodePc | input | W | Address of the decoded instruction |
| reqValid | input | 1 | An accepted interrupt request is pending |
| reqVector | input | VEC_W | Vector number of the request |
| reqLevel | input | LVL_W | Priority level of the request |
| vecBase | input | W | Base address of the vector table |
| cpuSr | input | W | Current status word |
| cpuSp | input | W | Current stack pointer |
| suppress | output | 1 | Squash the decoded instruction |
| busy | output | 1 | Entry sequence in progress |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | W | Access address |
| memWdata | output | W | Write data |
| memRdata | input | W | Read data, valid with memReady |
| memReady | input | 1 | Access completes this cycle |
| jumpValid | output | 1 | One-cycle redirect strobe |
| jumpPc | output | W | Handler start address |
| jumpSr | output | W | New status word |
| jumpSp | output | W | New stack pointer |

## Verification
Two events can fall in the same cycle: the redirect of one sequence and the arrival of the next request at a decode boundary. The bench watches for jumpValid and raises a fresh request with a different vector in exactly that cycle. It expects suppress to stay low there. On the following cycle it expects suppress high, with busy already low. The second sequence is then judged on its own vector address, pushed values and results. The sweep also raises a request in the middle of each sequence to confirm that nothing extra happens. It runs the sweep with memory latencies of zero to two wait cycles.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FETCH  = 3'd1,
    ST_PUSHSR = 3'd2,
    ST_PUSHPC = 3'd3,
    ST_JUMP   = 3'd4
  } seqState_e;

  typedef enum logic [1:0] {
    SEL_VEC = 2'd0,
    SEL_SR  = 2'd1,
    SEL_PC  = 2'd2
  } memSel_e;

  typedef struct packed {
    logic    capture;     // latch request and CPU context
    logic    loadHandler; // keep fetched handler address
    logic    pushDone;    // a push was acknowledged: move stack pointer
    logic    setMask;     // overwrite mask field with level
    memSel_e sel;         // address and data source
  } ctrlStrobes_t;

endpackage

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         decodeValid,
  input  logic         reqValid,
  input  logic         memReady,
  output logic         memReq,
  output logic         memWe,
  output logic         busy,
  output logic         suppress,
  output logic         jumpValid,
  output ctrlStrobes_t strobes
);

  seqState_e stateQ, stateD;
  logic      accept;

  assign accept = (stateQ == ST_IDLE) && decodeValid && reqValid;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:   if (accept)   stateD = ST_FETCH;
      ST_FETCH:  if (memReady) stateD = ST_PUSHSR;
      ST_PUSHSR: if (memReady) stateD = ST_PUSHPC;
      ST_PUSHPC: if (memReady) stateD = ST_JUMP;
      ST_JUMP:                 stateD = ST_IDLE;
      default:                 stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stateQ <= ST_IDLE;
    else        stateQ <= stateD;
  end

  always_comb begin
    strobes             = '0;
    strobes.sel         = SEL_VEC;
    strobes.capture     = accept;
    memReq              = 1'b0;
    memWe               = 1'b0;
    unique case (stateQ)
      ST_FETCH: begin
        memReq              = 1'b1;
        strobes.sel         = SEL_VEC;
        strobes.loadHandler = memReady;
      end
      ST_PUSHSR: begin
        memReq           = 1'b1;
        memWe            = 1'b1;
        strobes.sel      = SEL_SR;
        strobes.pushDone = memReady;
        strobes.setMask  = memReady;
      end
      ST_PUSHPC: begin
        memReq           = 1'b1;
        memWe            = 1'b1;
        strobes.sel      = SEL_PC;
        strobes.pushDone = memReady;
      end
      default: ;
    endcase
  end

  assign busy      = (stateQ != ST_IDLE);
  assign suppress  = accept;
  assign jumpValid = (stateQ == ST_JUMP);

endmodule

// File: rtl/irq_entry_dpath.sv
module irq_entry_dpath
  import irq_entry_pkg::*;
#(
  parameter int W        = 32,
  parameter int VEC_W    = 8,
  parameter int LVL_W    = 4,
  parameter int MASK_LSB = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobes_t     strobes,
  input  logic [W-1:0]     decodePc,
  input  logic [VEC_W-1:0] reqVector,
  input  logic [LVL_W-1:0] reqLevel,
  input  logic [W-1:0]     vecBase,
  input  logic [W-1:0]     cpuSr,
  input  logic [W-1:0]     cpuSp,
  input  logic [W-1:0]     memRdata,
  output logic [W-1:0]     memAddr,
  output logic [W-1:0]     memWdata,
  output logic [W-1:0]     handlerPc,
  output logic [W-1:0]     newSr,
  output logic [W-1:0]     newSp
);

  localparam int BYTES = W / 8;
  localparam int SHIFT = $clog2(BYTES);
  localparam logic [W-1:0] STEP = W'(BYTES);

  logic [W-1:0]     baseQ, pcQ, srQ, spQ, handlerQ;
  logic [VEC_W-1:0] vecQ;
  logic [LVL_W-1:0] lvlQ;
  logic [W-1:0]     vecOffset, pushAddr;

  assign vecOffset = W'(vecQ) << SHIFT;
  assign pushAddr  = spQ - STEP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baseQ    <= '0;
      pcQ      <= '0;
      srQ      <= '0;
      spQ      <= '0;
      handlerQ <= '0;
      vecQ     <= '0;
      lvlQ     <= '0;
    end else begin
      if (strobes.capture) begin
        baseQ <= vecBase;
        pcQ   <= decodePc;
        srQ   <= cpuSr;
        spQ   <= cpuSp;
        vecQ  <= reqVector;
        lvlQ  <= reqLevel;
      end
      if (strobes.loadHandler) handlerQ <= memRdata;
      if (strobes.pushDone)    spQ      <= pushAddr;
      if (strobes.setMask)     srQ[MASK_LSB +: LVL_W] <= lvlQ;
    end
  end

  always_comb begin
    unique case (strobes.sel)
      SEL_SR: begin
        memAddr  = pushAddr;
        memWdata = srQ;
      end
      SEL_PC: begin
        memAddr  = pushAddr;
        memWdata = pcQ;
      end
      default: begin
        memAddr  = baseQ + vecOffset;
        memWdata = '0;
      end
    endcase
  end

  assign handlerPc = handlerQ;
  assign newSr     = srQ;
  assign newSp     = spQ;

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int W        = 32,
  parameter int VEC_W    = 8,
  parameter int LVL_W    = 4,
  parameter int MASK_LSB = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             decodeValid,
  input  logic [W-1:0]     decodePc,
  input  logic             reqValid,
  input  logic [VEC_W-1:0] reqVector,
  input  logic [LVL_W-1:0] reqLevel,
  input  logic [W-1:0]     vecBase,
  input  logic [W-1:0]     cpuSr,
  input  logic [W-1:0]     cpuSp,
  output logic             suppress,
  output logic             busy,
  output logic             memReq,
  output logic             memWe,
  output logic [W-1:0]     memAddr,
  output logic [W-1:0]     memWdata,
  input  logic [W-1:0]     memRdata,
  input  logic             memReady,
  output logic             jumpValid,
  output logic [W-1:0]     jumpPc,
  output logic [W-1:0]     jumpSr,
  output logic [W-1:0]     jumpSp
);

  ctrlStrobes_t strobes;

  irq_entry_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .decodeValid (decodeValid),
    .reqValid    (reqValid),
    .memReady    (memReady),
    .memReq      (memReq),
    .memWe       (memWe),
    .busy        (busy),
    .suppress    (suppress),
    .jumpValid   (jumpValid),
    .strobes     (strobes)
  );

  irq_entry_dpath #(
    .W        (W),
    .VEC_W    (VEC_W),
    .LVL_W    (LVL_W),
    .MASK_LSB (MASK_LSB)
  ) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .decodePc  (decodePc),
    .reqVector (reqVector),
    .reqLevel  (reqLevel),
    .vecBase   (vecBase),
    .cpuSr     (cpuSr),
    .cpuSp     (cpuSp),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .handlerPc (jumpPc),
    .newSr     (jumpSr),
    .newSp     (jumpSp)
  );

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         suppress,
  input logic         memReq,
  input logic         memReady,
  input logic         memWe,
  input logic [W-1:0] memAddr,
  input logic [W-1:0] memWdata,
  input logic         jumpValid
);

  AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    suppress |=> busy); // R1

  AST_JUMP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    jumpValid |=> !jumpValid); // R5

  AST_JUMP_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    jumpValid |-> !memReq); // R5

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !suppress); // R8

  AST_NO_MEM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !memReq); // R8

  AST_HOLD_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(memWe)
                               && $stable(memWdata))); // R9

  AST_BUSY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    jumpValid |=> !busy); // R12

endmodule

bind irq_entry_seq irq_entry_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .suppress  (suppress),
  .memReq    (memReq),
  .memReady  (memReady),
  .memWe     (memWe),
  .memAddr   (memAddr),
  .memWdata  (memWdata),
  .jumpValid (jumpValid)
);

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int VEC_W = 8;
  localparam int LVL_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             decodeValid = 1'b0;
  logic [W-1:0]     decodePc = '0;
  logic             reqValid = 1'b0;
  logic [VEC_W-1:0] reqVector = '0;
  logic [LVL_W-1:0] reqLevel = '0;
  logic [W-1:0]     vecBase = '0;
  logic [W-1:0]     cpuSr = '0;
  logic [W-1:0]     cpuSp = '0;
  logic             suppress, busy, memReq, memWe, jumpValid;
  logic [W-1:0]     memAddr, memWdata, jumpPc, jumpSr, jumpSp;
  logic [W-1:0]     memRdata = '0;
  logic             memReady = 1'b0;

  int checks = 0;
  int errors = 0;
  int lat = 0;
  int waitCnt = 0;
  int cycle = 0;
  int logCnt = 0;
  logic [W-1:0] logAddr [0:7];
  logic [W-1:0] logData [0:7];
  logic         logWe   [0:7];
  int           logCyc  [0:7];
  logic         jmpSeen = 1'b0;
  int           jmpCyc = 0;
  logic [W-1:0] jmpPc, jmpSr, jmpSp;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_entry_seq u_dut (
    .clk (clk), .rst_n (rst_n),
    .decodeValid (decodeValid), .decodePc (decodePc),
    .reqValid (reqValid), .reqVector (reqVector), .reqLevel (reqLevel),
    .vecBase (vecBase), .cpuSr (cpuSr), .cpuSp (cpuSp),
    .suppress (suppress), .busy (busy),
    .memReq (memReq), .memWe (memWe), .memAddr (memAddr), .memWdata (memWdata),
    .memRdata (memRdata), .memReady (memReady),
    .jumpValid (jumpValid), .jumpPc (jumpPc), .jumpSr (jumpSr), .jumpSp (jumpSp)
  );

  function automatic logic [W-1:0] handlerOf(input logic [W-1:0] a);
    return (a * 32'h0001_0003) ^ 32'h8000_1234;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder and event recorder, all at the falling edge
  always @(negedge clk) begin
    cycle++;
    if (jumpValid) begin
      jmpSeen = 1'b1;
      jmpCyc  = cycle;
      jmpPc   = jumpPc;
      jmpSr   = jumpSr;
      jmpSp   = jumpSp;
    end
    if (memReq) begin
      if (waitCnt >= lat) begin
        memReady = 1'b1;
        memRdata = handlerOf(memAddr);
        if (logCnt < 8) begin
          logAddr[logCnt] = memAddr;
          logData[logCnt] = memWdata;
          logWe[logCnt]   = memWe;
          logCyc[logCnt]  = cycle;
        end
        logCnt++;
        waitCnt = 0;
      end else begin
        memReady = 1'b0;
        waitCnt++;
      end
    end else begin
      memReady = 1'b0;
      waitCnt  = 0;
    end
  end

  task automatic present(input logic [VEC_W-1:0] v, input logic [LVL_W-1:0] l,
                         input logic [W-1:0] pc, input logic [W-1:0] sr,
                         input logic [W-1:0] sp, input logic [W-1:0] base);
    reqVector = v; reqLevel = l; decodePc = pc;
    cpuSr = sr; cpuSp = sp; vecBase = base;
    decodeValid = 1'b1; reqValid = 1'b1;
  endtask

  task automatic waitJump();
    int n = 0;
    while (!jmpSeen && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk(jmpSeen, "R5 jump seen", W'(jmpSeen), 1);
  endtask

  task automatic judge(input logic [VEC_W-1:0] v, input logic [LVL_W-1:0] l,
                       input logic [W-1:0] pc, input logic [W-1:0] sr,
                       input logic [W-1:0] sp, input logic [W-1:0] base);
    logic [W-1:0] va, esr;
    va  = base + 32'(v) * 4;
    esr = (sr & ~32'h0000_00F0) | (32'(l) << 4);
    chk(logCnt == 3, "R8 access count", W'(logCnt), 3);
    chk(!logWe[0] && logAddr[0] == va, "R2 vector read", logAddr[0], va);
    chk(logWe[1] && logAddr[1] == sp - 4 && logData[1] == sr, "R3 SR push",
        logData[1], sr);
    chk(logWe[2] && logAddr[2] == sp - 8 && logData[2] == pc, "R4 PC push",
        logData[2], pc);
    chk(jmpCyc == logCyc[2] + 1, "R5 jump timing", W'(jmpCyc), W'(logCyc[2] + 1));
    chk(jmpPc == handlerOf(va), "R5 handler", jmpPc, handlerOf(va));
    chk(jmpSr == esr, "R6 mask", jmpSr, esr);
    chk(jmpSp == sp - 8, "R7 stack", jmpSp, sp - 8);
  endtask

  task automatic runOne(input logic [VEC_W-1:0] v, input logic [LVL_W-1:0] l,
                        input logic [W-1:0] pc, input logic [W-1:0] sr,
                        input logic [W-1:0] sp, input logic [W-1:0] base);
    @(negedge clk);
    logCnt = 0; jmpSeen = 1'b0;
    chk(!busy, "R12 idle before", W'(busy), 0);
    present(v, l, pc, sr, sp, base);
    #1;
    chk(suppress, "R1 suppress", W'(suppress), 1);
    @(negedge clk);
    decodeValid = 1'b0; reqValid = 1'b0;
    chk(busy, "R1 busy", W'(busy), 1);
    // a request mid-sequence must be ignored
    @(negedge clk);
    present(v ^ 8'h5A, ~l, pc ^ 32'hFFFF, ~sr, sp + 32'h100, base);
    #1;
    chk(!suppress, "R8 no accept while busy", W'(suppress), 0);
    @(negedge clk);
    decodeValid = 1'b0; reqValid = 1'b0;
    waitJump();
    @(negedge clk);
    chk(!busy, "R12 busy release", W'(busy), 0);
    judge(v, l, pc, sr, sp, base);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !memReq && !jumpValid && !suppress, "R10 reset state",
        W'({busy, memReq, jumpValid, suppress}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !memReq, "R10 after release", W'({busy, memReq}), 0);

    // sweep: latency x vector x level
    for (int la = 0; la < 3; la++) begin
      lat = la;
      for (int v = 0; v < 16; v++) begin
        runOne(VEC_W'(v * 17 + la), LVL_W'(v ^ la), 32'h0000_4000 + 32'(v) * 2,
               32'hFFFF_FF0F ^ (32'(v) << 12), 32'h0002_0000 - 32'(v) * 16,
               32'h0000_0400 * 32'(la + 1));
      end
    end
    // corners: top vector, all-ones SR, level zero, stack near zero
    lat = 1;
    runOne(8'hFF, 4'h0, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'h0000_0008, 32'h0);
    runOne(8'h00, 4'hF, 32'h0, 32'h0, 32'h8000_0000, 32'hFFFF_FC00);

    // R11: request arrives in the jump cycle
    lat = 0;
    @(negedge clk);
    logCnt = 0; jmpSeen = 1'b0;
    present(8'h10, 4'h3, 32'h100, 32'h0, 32'h1000, 32'h0);
    @(negedge clk);
    decodeValid = 1'b0; reqValid = 1'b0;
    while (!jumpValid) @(negedge clk);
    present(8'h22, 4'h9, 32'h2468, 32'h0000_00F0, 32'h3000, 32'h800);
    #1;
    chk(!suppress, "R11 no accept in jump cycle", W'(suppress), 0);
    @(negedge clk);
    chk(suppress && !busy, "R11 accepted next cycle", W'({suppress, busy}), 2'b10);
    logCnt = 0; jmpSeen = 1'b0;
    @(negedge clk);
    decodeValid = 1'b0; reqValid = 1'b0;
    waitJump();
    @(negedge clk);
    judge(8'h22, 4'h9, 32'h2468, 32'h0000_00F0, 32'h3000, 32'h800);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule